// File: doc/BRIEF.md
# Banked Nibble Data Memory

This block is the data store of a small 4-bit controller core. A request carries a 12-bit address and an access kind. The top four address bits choose a bank. Banks 0 and 1 are backed by on-chip nibble storage of 256 words each, 512 nibbles in all. The upper half of bank 15 is a window onto peripheral registers, which sit outside the block. Every other location has no storage behind it.

One store serves three access widths. A nibble access touches one word. A byte access touches an even-aligned pair of words. A bit access tests, sets or clears one bit of a word. Each bank keeps even and odd words in separate lanes, so a byte access needs only one cycle. A bit set or clear is a read-modify-write inside a single cycle. The low 32 words of bank 0 also serve the core as its general register file, through this same storage.

Every request gets exactly one response, one cycle later. The response carries the read data and two flags: misalignment and invalid access. A peripheral access is passed straight through to the peripheral port in the request cycle.

Top module: `nibble_bank_mem`

## Requirements
- R1: After reset, rsp_valid, rsp_rdata, rsp_invalid and rsp_misalign are all zero. rsp_valid is high in the cycle after each cycle with req_valid high, and is low otherwise.
- R2: Address bits [11:8] select the bank. Bank 0 and bank 1 are separate 256-nibble stores. A word written at offset X of one bank does not change offset X of the other bank.
- R3: Kind 0 (nibble read) returns the addressed word in rsp_rdata[3:0], with rsp_rdata[7:4] zero. Kind 1 (nibble write) stores req_wdata[3:0]. Every write kind (1, 3, 5, 6) answers with rsp_rdata zero, except that kinds 5 and 6 also return the old bit (see R6).
- R4: Kind 2 (byte read) and kind 3 (byte write) at an even address A pair word A, which is bits [3:0], with word A+1, which is bits [7:4]. A byte write is seen afterwards by nibble reads of both words.
- R5: A byte kind (2 or 3) at an odd address sets rsp_misalign for that one response. It leaves rsp_invalid low and rsp_rdata zero, writes nothing and does not raise pio_en.
- R6: Kind 5 (bit set) and kind 6 (bit clear) change only bit req_bit of the addressed word. Both return that bit's previous value in rsp_rdata[0], with the other bits of rsp_rdata zero. The new value is seen by the next read.
- R7: Kind 4 (bit test) returns bit req_bit of the addressed word in rsp_rdata[0] and leaves the word unchanged.
- R8: Addresses F80h to FFFh with kinds 0 to 3 go to the peripheral port in the request cycle. The port sees pio_en high, pio_we for kinds 1 and 3, pio_byte for kinds 2 and 3, pio_addr equal to address bits [6:0], and pio_wdata equal to req_wdata. A read returns the pio_rdata value sampled at the end of that cycle, unchanged. No RAM word changes.
- R9: The following accesses set rsp_invalid with rsp_rdata zero and no write: any bank other than 0, 1 and 15; addresses F00h to F7Fh; a bit kind (4 to 6) in the peripheral window; and kind 7. In these cases pio_en stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Access kind 0 to 7 |
| req_addr | input | 12 | Word address; [11:8] is the bank |
| req_wdata | input | 8 | Write data; [3:0] is used for nibble writes |
| req_bit | input | 2 | Bit select for bit kinds |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 8 | Read data |
| rsp_invalid | output | 1 | Access had no backing storage |
| rsp_misalign | output | 1 | Byte access at an odd address |
| pio_en | output | 1 | Peripheral access this cycle |
| pio_we | output | 1 | Peripheral write |
| pio_byte | output | 1 | Peripheral access is a byte |
| pio_addr | output | 7 | Offset inside the peripheral window |
| pio_wdata | output | 8 | Peripheral write data |
| pio_rdata | input | 8 | Peripheral read data |

## Verification
The bench goes after the bank boundary. It writes through banks 3 and 15 and reads back banks 0 and 1, which catches a decoder that compares only the low bank bit: such a decoder would alias those writes into RAM. Odd-address byte writes are followed by reads of the pair. A design that still wrote would show a changed high or low word, and one that swapped the lanes would return the nibbles reversed. Bit set and clear are applied to bits that are already set or already clear, so a wrong mask shows up as changed neighbouring bits or a wrong old-bit value. Accesses just below F80h and bit kinds inside the window must neither reach the port nor return data.

// File: rtl/nbm_pkg.sv
package nbm_pkg;

  typedef enum logic [2:0] {
    K_NIB_RD  = 3'd0,
    K_NIB_WR  = 3'd1,
    K_BYTE_RD = 3'd2,
    K_BYTE_WR = 3'd3,
    K_BIT_TST = 3'd4,
    K_BIT_SET = 3'd5,
    K_BIT_CLR = 3'd6,
    K_RSVD    = 3'd7
  } acc_kind_e;

  typedef enum logic [1:0] {
    RG_RAM    = 2'd0,
    RG_PERIPH = 2'd1,
    RG_NONE   = 2'd2
  } region_e;

  typedef struct packed {
    region_e region;
    logic    misalign;
    logic    invalid;
    logic    wr;
    logic    byte_acc;
    logic    bit_acc;
    logic    bit_set;
    logic    bit_clr;
  } dec_t;

endpackage

// File: rtl/nbm_decode.sv
module nbm_decode
  import nbm_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int BANK_W        = 4,
  parameter int NUM_RAM_BANKS = 2,
  parameter int PERIPH_BANK   = 15
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        kind,
  output dec_t              dec
);

  localparam int OFFS_W = ADDR_W - BANK_W;
  localparam logic [BANK_W-1:0] RAM_LIMIT = BANK_W'(NUM_RAM_BANKS);
  localparam logic [BANK_W-1:0] PER_BANK  = BANK_W'(PERIPH_BANK);

  logic [BANK_W-1:0] bank;
  logic [OFFS_W-1:0] offs;
  acc_kind_e         k;
  logic              in_ram;
  logic              in_win;

  assign bank   = addr[ADDR_W-1 -: BANK_W];
  assign offs   = addr[OFFS_W-1:0];
  assign k      = acc_kind_e'(kind);
  assign in_ram = (bank < RAM_LIMIT);
  assign in_win = (bank == PER_BANK) && offs[OFFS_W-1];

  always_comb begin
    dec          = '0;
    dec.region   = RG_NONE;
    dec.byte_acc = (k == K_BYTE_RD) || (k == K_BYTE_WR);
    dec.bit_acc  = (k == K_BIT_TST) || (k == K_BIT_SET) || (k == K_BIT_CLR);
    dec.bit_set  = (k == K_BIT_SET);
    dec.bit_clr  = (k == K_BIT_CLR);
    dec.wr       = (k == K_NIB_WR) || (k == K_BYTE_WR) ||
                   (k == K_BIT_SET) || (k == K_BIT_CLR);
    if (dec.byte_acc && addr[0]) begin
      dec.misalign = 1'b1;
    end else if (k == K_RSVD) begin
      dec.invalid = 1'b1;
    end else if (in_ram) begin
      dec.region = RG_RAM;
    end else if (in_win && !dec.bit_acc) begin
      dec.region = RG_PERIPH;
    end else begin
      dec.invalid = 1'b1;
    end
  end

endmodule

// File: rtl/nbm_ram_bank.sv
module nbm_ram_bank #(
  parameter int ROWS  = 128,
  parameter int NIB_W = 4,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic [1:0]         lane_we,
  input  logic [ROW_W-1:0]   row,
  input  logic [2*NIB_W-1:0] wdata,
  output logic [2*NIB_W-1:0] rdata
);

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    logic [NIB_W-1:0] store [ROWS];

    always_ff @(posedge clk) begin
      if (lane_we[ln]) begin
        store[row] <= wdata[ln*NIB_W +: NIB_W];
      end
    end

    assign rdata[ln*NIB_W +: NIB_W] = store[row];
  end

endmodule

// File: rtl/nbm_bitop.sv
module nbm_bitop #(
  parameter int NIB_W = 4,
  localparam int SEL_W = $clog2(NIB_W)
) (
  input  logic [NIB_W-1:0] old_nib,
  input  logic [SEL_W-1:0] sel,
  input  logic             do_set,
  input  logic             do_clr,
  output logic [NIB_W-1:0] new_nib,
  output logic             old_bit
);

  logic [NIB_W-1:0] mask;

  assign mask    = NIB_W'(1) << sel;
  assign old_bit = |(old_nib & mask);

  always_comb begin
    new_nib = old_nib;
    if (do_set) begin
      new_nib = old_nib | mask;
    end else if (do_clr) begin
      new_nib = old_nib & ~mask;
    end
  end

endmodule

// File: rtl/nibble_bank_mem.sv
module nibble_bank_mem
  import nbm_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int BANK_W        = 4,
  parameter int NIB_W         = 4,
  parameter int NUM_RAM_BANKS = 2,
  parameter int PERIPH_BANK   = 15,
  localparam int OFFS_W = ADDR_W - BANK_W,
  localparam int BYTE_W = 2 * NIB_W,
  localparam int SEL_W  = $clog2(NIB_W),
  localparam int PIO_AW = OFFS_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic [SEL_W-1:0]  req_bit,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              rsp_invalid,
  output logic              rsp_misalign,
  output logic              pio_en,
  output logic              pio_we,
  output logic              pio_byte,
  output logic [PIO_AW-1:0] pio_addr,
  output logic [BYTE_W-1:0] pio_wdata,
  input  logic [BYTE_W-1:0] pio_rdata
);

  localparam int ROW_W = OFFS_W - 1;
  localparam int ROWS  = 2 ** ROW_W;
  localparam int RB_W  = $clog2(NUM_RAM_BANKS);

  dec_t              dec;
  logic [ROW_W-1:0]  row;
  logic              lane;
  logic [RB_W-1:0]   bank_idx;
  logic [BYTE_W-1:0] bank_rdata [NUM_RAM_BANKS];
  logic [1:0]        bank_we    [NUM_RAM_BANKS];
  logic [BYTE_W-1:0] ram_rd;
  logic [NIB_W-1:0]  old_nib;
  logic [NIB_W-1:0]  new_nib;
  logic              old_bit;
  logic              ram_go;
  logic [1:0]        lane_we_c;
  logic [BYTE_W-1:0] ram_wdata;

  logic              valid_d;
  logic [BYTE_W-1:0] rdata_d;
  logic              inv_d;
  logic              mis_d;

  nbm_decode #(
    .ADDR_W        (ADDR_W),
    .BANK_W        (BANK_W),
    .NUM_RAM_BANKS (NUM_RAM_BANKS),
    .PERIPH_BANK   (PERIPH_BANK)
  ) u_decode (
    .addr (req_addr),
    .kind (req_kind),
    .dec  (dec)
  );

  assign row      = req_addr[OFFS_W-1:1];
  assign lane     = req_addr[0];
  assign bank_idx = req_addr[OFFS_W +: RB_W];

  for (genvar b = 0; b < NUM_RAM_BANKS; b++) begin : g_bank
    assign bank_we[b] = (ram_go && (bank_idx == RB_W'(b))) ? lane_we_c : 2'b00;

    nbm_ram_bank #(
      .ROWS  (ROWS),
      .NIB_W (NIB_W)
    ) u_bank (
      .clk     (clk),
      .lane_we (bank_we[b]),
      .row     (row),
      .wdata   (ram_wdata),
      .rdata   (bank_rdata[b])
    );
  end

  assign ram_rd  = bank_rdata[bank_idx];
  assign old_nib = lane ? ram_rd[NIB_W +: NIB_W] : ram_rd[0 +: NIB_W];

  nbm_bitop #(
    .NIB_W (NIB_W)
  ) u_bitop (
    .old_nib (old_nib),
    .sel     (req_bit),
    .do_set  (dec.bit_set),
    .do_clr  (dec.bit_clr),
    .new_nib (new_nib),
    .old_bit (old_bit)
  );

  // RAM write path: lane enables and data
  always_comb begin
    ram_go = req_valid && (dec.region == RG_RAM) && dec.wr;
    if (dec.byte_acc) begin
      lane_we_c = 2'b11;
      ram_wdata = req_wdata;
    end else begin
      lane_we_c = lane ? 2'b10 : 2'b01;
      if (dec.bit_acc) begin
        ram_wdata = {new_nib, new_nib};
      end else begin
        ram_wdata = {req_wdata[NIB_W-1:0], req_wdata[NIB_W-1:0]};
      end
    end
  end

  // Peripheral pass-through in the request cycle
  always_comb begin
    pio_en    = req_valid && (dec.region == RG_PERIPH);
    pio_we    = pio_en && dec.wr;
    pio_byte  = pio_en && dec.byte_acc;
    pio_addr  = req_addr[PIO_AW-1:0];
    pio_wdata = pio_en ? req_wdata : '0;
  end

  // Response next-state
  always_comb begin
    valid_d = req_valid;
    inv_d   = req_valid && dec.invalid;
    mis_d   = req_valid && dec.misalign;
    rdata_d = '0;
    if (req_valid) begin
      unique case (dec.region)
        RG_RAM: begin
          if (dec.bit_acc) begin
            rdata_d = BYTE_W'(old_bit);
          end else if (!dec.wr) begin
            rdata_d = dec.byte_acc ? ram_rd : BYTE_W'(old_nib);
          end
        end
        RG_PERIPH: begin
          if (!dec.wr) begin
            rdata_d = pio_rdata;
          end
        end
        default: rdata_d = '0;
      endcase
    end
  end

  // Response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      rsp_invalid  <= 1'b0;
      rsp_misalign <= 1'b0;
    end else begin
      rsp_valid    <= valid_d;
      rsp_rdata    <= rdata_d;
      rsp_invalid  <= inv_d;
      rsp_misalign <= mis_d;
    end
  end

endmodule

// File: rtl/nbm_chk.sv
module nbm_chk #(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 4,
  parameter int BYTE_W = 8,
  parameter int PIO_AW = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_kind,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [BYTE_W-1:0] rsp_rdata,
  input logic              rsp_invalid,
  input logic              rsp_misalign,
  input logic              pio_en,
  input logic              pio_we
);

  localparam int OFFS_W = ADDR_W - BANK_W;

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R3
  write_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 3'd1 || req_kind == 3'd3)) |=> (rsp_rdata == '0));

  // R5
  odd_byte_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 3'd2 || req_kind == 3'd3) && req_addr[0])
      |=> (rsp_misalign && !rsp_invalid && rsp_rdata == '0));

  // R5
  odd_byte_no_pio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_kind == 3'd2 || req_kind == 3'd3) && req_addr[0]) |-> !pio_en);

  // R8
  pio_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pio_en |-> (req_valid && (&req_addr[ADDR_W-1 -: BANK_W]) &&
                req_addr[OFFS_W-1] && req_kind < 3'd4));

  // R8
  pio_we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pio_we |-> pio_en);

  // R9
  invalid_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_invalid |-> (rsp_rdata == '0 && !rsp_misalign && rsp_valid));

endmodule

bind nibble_bank_mem nbm_chk #(
  .ADDR_W (ADDR_W),
  .BANK_W (BANK_W),
  .BYTE_W (BYTE_W),
  .PIO_AW (PIO_AW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_kind     (req_kind),
  .req_addr     (req_addr),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .rsp_invalid  (rsp_invalid),
  .rsp_misalign (rsp_misalign),
  .pio_en       (pio_en),
  .pio_we       (pio_we)
);

// File: tb/nibble_bank_mem_tb.sv
module nibble_bank_mem_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [11:0] req_addr;
  logic [7:0]  req_wdata;
  logic [1:0]  req_bit;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        rsp_invalid;
  logic        rsp_misalign;
  logic        pio_en;
  logic        pio_we;
  logic        pio_byte;
  logic [6:0]  pio_addr;
  logic [7:0]  pio_wdata;
  logic [7:0]  pio_rdata;

  int nchk  = 0;
  int nfail = 0;
  logic [3:0] ref_mem [512];

  nibble_bank_mem u_dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_kind (req_kind), .req_addr (req_addr),
    .req_wdata (req_wdata), .req_bit (req_bit),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .rsp_invalid (rsp_invalid), .rsp_misalign (rsp_misalign),
    .pio_en (pio_en), .pio_we (pio_we), .pio_byte (pio_byte),
    .pio_addr (pio_addr), .pio_wdata (pio_wdata), .pio_rdata (pio_rdata)
  );

  function automatic logic [7:0] pio_model(input logic [6:0] a);
    return {a[3:0] ^ 4'hA, 1'b1, a[6:4]};
  endfunction

  assign pio_rdata = pio_model(pio_addr);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic report(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] kind, input logic [11:0] addr,
                     input logic [7:0] wd, input logic [1:0] bsel, input string tag);
    logic [3:0] bank;
    logic       mis, inv, ram, per;
    logic [8:0] idx;
    logic [7:0] exp_rd;
    logic [3:0] nib;
    bank = addr[11:8];
    mis  = (kind == 3'd2 || kind == 3'd3) && addr[0];
    inv  = !mis && (kind == 3'd7 ||
           !(bank < 4'd2 || (bank == 4'hF && addr[7] && kind < 3'd4)));
    ram  = !mis && !inv && bank < 4'd2;
    per  = !mis && !inv && bank == 4'hF;
    idx  = {bank[0], addr[7:0]};
    exp_rd = 8'h00;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = addr;
    req_wdata = wd; req_bit = bsel;
    #1;
    report(tag, "pio", {pio_en, pio_we, pio_byte, pio_addr, pio_wdata},
           per ? {1'b1, kind == 3'd1 || kind == 3'd3, kind == 3'd2 || kind == 3'd3,
                  addr[6:0], wd}
               : {1'b0, pio_we, pio_byte, pio_addr, pio_wdata});
    if (ram) begin
      case (kind)
        3'd0: exp_rd = {4'h0, ref_mem[idx]};
        3'd1: ref_mem[idx] = wd[3:0];
        3'd2: exp_rd = {ref_mem[idx + 9'd1], ref_mem[idx]};
        3'd3: begin ref_mem[idx] = wd[3:0]; ref_mem[idx + 9'd1] = wd[7:4]; end
        3'd4: exp_rd = {7'h0, ref_mem[idx][bsel]};
        3'd5: begin
          nib = ref_mem[idx]; exp_rd = {7'h0, nib[bsel]};
          nib[bsel] = 1'b1; ref_mem[idx] = nib;
        end
        3'd6: begin
          nib = ref_mem[idx]; exp_rd = {7'h0, nib[bsel]};
          nib[bsel] = 1'b0; ref_mem[idx] = nib;
        end
        default: exp_rd = 8'h00;
      endcase
    end else if (per && (kind == 3'd0 || kind == 3'd2)) begin
      exp_rd = pio_model(addr[6:0]);
    end
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    report(tag, "rsp", {rsp_valid, rsp_rdata, rsp_invalid, rsp_misalign},
           {1'b1, exp_rd, inv, mis});
  endtask

  function automatic string tag_for(input logic [2:0] kind, input logic [11:0] addr);
    if ((kind == 3'd2 || kind == 3'd3) && addr[0]) return "R5";
    if (kind == 3'd7 || !(addr[11:8] < 4'd2 || (addr[11:8] == 4'hF && addr[7]))) return "R9";
    if (addr[11:8] == 4'hF) return (kind < 3'd4) ? "R8" : "R9";
    case (kind)
      3'd0, 3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4:       return "R7";
      default:    return "R6";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [11:0] ra;
    logic [2:0]  rk;
    int          sel;
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_addr = '0;
    req_wdata = '0; req_bit = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    report("R1", "reset", {rsp_valid, rsp_rdata, rsp_invalid, rsp_misalign}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // fill both RAM banks with byte writes
    for (int i = 0; i < 256; i++) begin
      run(3'd3, {3'b000, i[7], i[6:0], 1'b0}, 8'($urandom), 2'd0, "R4");
    end
    @(negedge clk); #1;
    // R1 idle cycle gives no response
    report("R1", "idle", {31'd0, rsp_valid}, 32'd0);

    // R2 banks are distinct
    run(3'd1, 12'h045, 8'h03, 2'd0, "R2");
    run(3'd1, 12'h145, 8'h0C, 2'd0, "R2");
    run(3'd0, 12'h045, 8'h00, 2'd0, "R2");
    run(3'd0, 12'h145, 8'h00, 2'd0, "R2");
    // R3 general register area word
    run(3'd1, 12'h01F, 8'hF9, 2'd0, "R3");
    run(3'd0, 12'h01F, 8'h00, 2'd0, "R3");
    // R4 byte lane order
    run(3'd3, 12'h0A2, 8'h7E, 2'd0, "R4");
    run(3'd0, 12'h0A2, 8'h00, 2'd0, "R4");
    run(3'd0, 12'h0A3, 8'h00, 2'd0, "R4");
    run(3'd2, 12'h0A2, 8'h00, 2'd0, "R4");
    // R5 odd byte rejected, pair intact
    run(3'd3, 12'h0A3, 8'h11, 2'd0, "R5");
    run(3'd2, 12'h0A3, 8'h00, 2'd0, "R5");
    run(3'd2, 12'h0A2, 8'h00, 2'd0, "R5");
    // R6 set an already-set bit, set a clear bit, clear a set bit
    run(3'd5, 12'h0A2, 8'h00, 2'd2, "R6");
    run(3'd5, 12'h0A2, 8'h00, 2'd0, "R6");
    run(3'd6, 12'h0A2, 8'h00, 2'd3, "R6");
    run(3'd6, 12'h0A2, 8'h00, 2'd3, "R6");
    run(3'd0, 12'h0A2, 8'h00, 2'd0, "R6");
    // R7 bit test leaves word
    run(3'd4, 12'h0A2, 8'h00, 2'd1, "R7");
    run(3'd0, 12'h0A2, 8'h00, 2'd0, "R7");
    // R8 peripheral window
    run(3'd0, 12'hF85, 8'h00, 2'd0, "R8");
    run(3'd3, 12'hFA0, 8'h5B, 2'd0, "R8");
    run(3'd2, 12'hFFE, 8'h00, 2'd0, "R8");
    run(3'd1, 12'hF80, 8'h06, 2'd0, "R8");
    run(3'd2, 12'h1A0, 8'h00, 2'd0, "R8");
    // R9 unmapped and rejected accesses
    run(3'd1, 12'h3A2, 8'h05, 2'd0, "R9");
    run(3'd2, 12'h1A2, 8'h00, 2'd0, "R9");
    run(3'd0, 12'h0A2, 8'h00, 2'd0, "R9");
    run(3'd1, 12'hF7F, 8'h04, 2'd0, "R9");
    run(3'd5, 12'hF90, 8'h00, 2'd1, "R9");
    run(3'd7, 12'h010, 8'hFF, 2'd0, "R9");
    run(3'd0, 12'h2A0, 8'h00, 2'd0, "R9");
    run(3'd0, 12'h010, 8'h00, 2'd0, "R9");

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      sel = int'($urandom % 8);
      if (sel < 5)      ra = {3'b000, 1'($urandom), 8'($urandom)};
      else if (sel < 7) ra = {5'b11111, 7'($urandom)};
      else              ra = 12'($urandom);
      rk = 3'($urandom);
      run(rk, ra, 8'($urandom), 2'($urandom), tag_for(rk, ra));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule